// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets bus write cycles aimed at a byte-wide parallel flash array with a 20-bit address. A write is taken when chip enable and write enable go low while output enable is high. The block follows multi-write unlock sequences. When a sequence completes, it issues a one-cycle request to the array (byte program or chip erase), sets a sticky boot-region lock, or moves in and out of an identification mode. The array and its timing sit outside the block and answer each request with an acknowledge. From the request until that acknowledge the block reports busy.

A 16 KB boot region sits at the bottom or at the top of the address space, chosen by a parameter. Once the lock is set, program requests into that region are dropped and erase requests ask the array to keep the region intact. A high-voltage override input lifts both restrictions for as long as it is asserted. The decoder performs the read-modify step of a program itself. The data sent to the array is the byte currently stored at the target ANDed with the new byte, so a program can only clear bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is counted once, at the first clock where busCe_n=0, busWe_n=0 and busOe_n=1 after a clock where that was not so. A write held for several cycles counts once. A cycle with busOe_n=0 is not a write.
- R2: The writes AA@05555, 55@02AAA, A0@05555 arm a program. The next write (address T, data D) makes arrayReq high for exactly the one cycle after that write is sampled, with arrayOp=2'b01 and arrayAddr=T.
- R3: The programmed byte arrayWrData equals arrayRdData at T (the old byte) AND D.
- R4: The writes AA@05555, 55@02AAA, 80@05555, AA@05555, 55@02AAA, 10@05555 make a one-cycle arrayReq with arrayOp=2'b10. arrayKeepBoot is 1 exactly when the lock is set and hvOverride is low.
- R5: The same six writes ending in 40@05555 set bootLocked. No command clears it. Its value after reset is the parameter INIT_LOCKED.
- R6: The boot region is addresses 0x00000-0x03FFF when BOOT_TOP=0 and 0xFC000-0xFFFFF when BOOT_TOP=1. With the lock set and hvOverride low, a program into the region issues no request. A program outside the region still does.
- R7: With hvOverride high, a program into the locked boot region issues its request and an erase reports arrayKeepBoot=0.
- R8: The writes AA@05555, 55@02AAA, 90@05555 enter identification mode (idMode=1). There, reading address 0x00002 gives busRdData bit 0 = bootLocked with the other bits 0, and any other address reads 0x00. Outside the mode, busRdData equals arrayRdData.
- R9: Identification mode is left either by AA@05555, 55@02AAA, F0@05555 or by a single F0 write to any address.
- R10: A write that does not match the expected next step returns the decoder to idle and is then judged again as a first unlock write. For example, AA, AA, 55, A0 still arms a program.
- R11: busy is 1 from the request cycle until the cycle after arrayAck. Writes arriving while busy is 1 are ignored and advance no sequence.
- R12: After reset, arrayReq=0, busy=0 and idMode=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busAddr | input | 20 | Bus address |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Read data (identification value or array byte) |
| busCe_n | input | 1 | Chip enable, active low |
| busOe_n | input | 1 | Output enable, active low |
| busWe_n | input | 1 | Write enable, active low |
| hvOverride | input | 1 | High-voltage lock override |
| arrayRdAddr | output | 20 | Array read address (follows busAddr) |
| arrayRdData | input | 8 | Array byte at arrayRdAddr |
| arrayReq | output | 1 | One-cycle operation request |
| arrayOp | output | 2 | 01 program, 10 erase |
| arrayAddr | output | 20 | Program target address |
| arrayWrData | output | 8 | Byte to store |
| arrayKeepBoot | output | 1 | Erase must spare the boot region |
| arrayAck | input | 1 | Array finished the operation |
| busy | output | 1 | Operation outstanding |
| bootLocked | output | 1 | Sticky boot lock |
| idMode | output | 1 | Identification mode active |

## Verification
A wrong sequence state has no output of its own. It shows up only at the last write of a sequence, as a request that is missing, extra or has the wrong opcode, one cycle after that write. The directed scenarios therefore end every sequence with a request count check. A wrong lock or region decode shows on the next program into the boot region or the next erase. A wrong mode flag shows on the very next read, since busRdData is combinational. A busy flag stuck low lets a second request through inside the acknowledge window, which the busy scenario counts.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_ARMED,
    ST_ERA_80,
    ST_ERA_UNL1,
    ST_ERA_UNL2
  } seqState_t;

  localparam logic [1:0] OP_NONE    = 2'b00;
  localparam logic [1:0] OP_PROGRAM = 2'b01;
  localparam logic [1:0] OP_ERASE   = 2'b10;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CODE_PGM   = 8'hA0;
  localparam logic [7:0]  CODE_ERPRE = 8'h80;
  localparam logic [7:0]  CODE_ERASE = 8'h10;
  localparam logic [7:0]  CODE_LOCK  = 8'h40;
  localparam logic [7:0]  CODE_IDIN  = 8'h90;
  localparam logic [7:0]  CODE_IDOUT = 8'hF0;

  typedef struct packed {
    logic doProgram;
    logic doErase;
    logic doLock;
    logic idEnter;
    logic idExit;
  } cmdStrobes_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busCe_n,
  input  logic              busOe_n,
  input  logic              busWe_n,
  input  logic              busy,
  output cmdStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

  seqState_t state, stateNext;
  logic wrLevel, wrLevelPrev, wrEvent;
  logic isKeyA, isKeyB, atAddrA;

  assign wrLevel = !busCe_n && !busWe_n && busOe_n;
  assign wrEvent = wrLevel && !wrLevelPrev && !busy;

  assign atAddrA = (busAddr == ADDR_A);
  assign isKeyA  = atAddrA && (busWrData == DATA_W'(KEY_DATA_A));
  assign isKeyB  = (busAddr == ADDR_B) && (busWrData == DATA_W'(KEY_DATA_B));

  always_comb begin
    logic restart;
    stateNext = state;
    strobes   = '0;
    restart   = 1'b0;
    if (wrEvent) begin
      unique case (state)
        ST_IDLE:     restart = 1'b1;
        ST_UNL1:     if (isKeyB) stateNext = ST_UNL2; else restart = 1'b1;
        ST_UNL2: begin
          stateNext = ST_IDLE;
          if (atAddrA && busWrData == DATA_W'(CODE_PGM))        stateNext = ST_PGM_ARMED;
          else if (atAddrA && busWrData == DATA_W'(CODE_ERPRE)) stateNext = ST_ERA_80;
          else if (atAddrA && busWrData == DATA_W'(CODE_IDIN))  strobes.idEnter = 1'b1;
          else restart = 1'b1;
        end
        ST_PGM_ARMED: begin
          strobes.doProgram = 1'b1;
          stateNext         = ST_IDLE;
        end
        ST_ERA_80:   if (isKeyA) stateNext = ST_ERA_UNL1; else restart = 1'b1;
        ST_ERA_UNL1: if (isKeyB) stateNext = ST_ERA_UNL2; else restart = 1'b1;
        ST_ERA_UNL2: begin
          stateNext = ST_IDLE;
          if (atAddrA && busWrData == DATA_W'(CODE_ERASE))     strobes.doErase = 1'b1;
          else if (atAddrA && busWrData == DATA_W'(CODE_LOCK)) strobes.doLock  = 1'b1;
          else restart = 1'b1;
        end
        default:     stateNext = ST_IDLE;
      endcase
      // a write that breaks a sequence is judged again as a fresh start
      if (restart) begin
        if (isKeyA) begin
          stateNext = ST_UNL1;
        end else begin
          stateNext = ST_IDLE;
          if (busWrData == DATA_W'(CODE_IDOUT)) strobes.idExit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wrLevelPrev <= 1'b0;
    end else begin
      state       <= stateNext;
      wrLevelPrev <= wrLevel;
    end
  end

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int BOOT_LOG2   = 14,
  parameter bit INIT_LOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmdStrobes_t       strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              hvOverride,
  input  logic [DATA_W-1:0] arrayRdData,
  input  logic              arrayAck,
  output logic [DATA_W-1:0] busRdData,
  output logic              arrayReq,
  output logic [1:0]        arrayOp,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [DATA_W-1:0] arrayWrData,
  output logic              arrayKeepBoot,
  output logic              busy,
  output logic              bootLocked,
  output logic              idMode
);

  localparam int HI_W = ADDR_W - BOOT_LOG2;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2);

  logic inBoot, lockBlocks, pgmAllowed;

  generate
    if (BOOT_TOP) begin : g_topBoot
      assign inBoot = (busAddr[ADDR_W-1:BOOT_LOG2] == {HI_W{1'b1}});
    end else begin : g_bottomBoot
      assign inBoot = (busAddr[ADDR_W-1:BOOT_LOG2] == {HI_W{1'b0}});
    end
  endgenerate

  assign lockBlocks = bootLocked && !hvOverride;
  assign pgmAllowed = !(inBoot && lockBlocks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrayReq      <= 1'b0;
      arrayOp       <= OP_NONE;
      arrayAddr     <= '0;
      arrayWrData   <= '0;
      arrayKeepBoot <= 1'b0;
      busy          <= 1'b0;
      bootLocked    <= INIT_LOCKED;
      idMode        <= 1'b0;
    end else begin
      arrayReq <= 1'b0;
      if (arrayAck) busy <= 1'b0;
      if (strobes.doProgram && pgmAllowed) begin
        arrayReq      <= 1'b1;
        arrayOp       <= OP_PROGRAM;
        arrayAddr     <= busAddr;
        arrayWrData   <= arrayRdData & busWrData;
        arrayKeepBoot <= 1'b0;
        busy          <= 1'b1;
      end
      if (strobes.doErase) begin
        arrayReq      <= 1'b1;
        arrayOp       <= OP_ERASE;
        arrayAddr     <= '0;
        arrayWrData   <= '1;
        arrayKeepBoot <= lockBlocks;
        busy          <= 1'b1;
      end
      if (strobes.doLock)  bootLocked <= 1'b1;
      if (strobes.idEnter) idMode     <= 1'b1;
      if (strobes.idExit)  idMode     <= 1'b0;
    end
  end

  always_comb begin
    if (idMode) busRdData = (busAddr == STATUS_ADDR) ? DATA_W'(bootLocked) : '0;
    else        busRdData = arrayRdData;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int BOOT_LOG2   = 14,
  parameter bit INIT_LOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              busCe_n,
  input  logic              busOe_n,
  input  logic              busWe_n,
  input  logic              hvOverride,
  output logic [ADDR_W-1:0] arrayRdAddr,
  input  logic [DATA_W-1:0] arrayRdData,
  output logic              arrayReq,
  output logic [1:0]        arrayOp,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [DATA_W-1:0] arrayWrData,
  output logic              arrayKeepBoot,
  input  logic              arrayAck,
  output logic              busy,
  output logic              bootLocked,
  output logic              idMode
);

  cmdStrobes_t strobes;

  assign arrayRdAddr = busAddr;

  flash_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busCe_n(busCe_n), .busOe_n(busOe_n), .busWe_n(busWe_n),
    .busy(busy), .strobes(strobes)
  );

  flash_cmd_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP),
    .BOOT_LOG2(BOOT_LOG2), .INIT_LOCKED(INIT_LOCKED)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .busAddr(busAddr),
    .busWrData(busWrData), .hvOverride(hvOverride), .arrayRdData(arrayRdData),
    .arrayAck(arrayAck), .busRdData(busRdData), .arrayReq(arrayReq),
    .arrayOp(arrayOp), .arrayAddr(arrayAddr), .arrayWrData(arrayWrData),
    .arrayKeepBoot(arrayKeepBoot), .busy(busy), .bootLocked(bootLocked),
    .idMode(idMode)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter bit BOOT_TOP  = 1'b0,
  parameter int BOOT_LOG2 = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] busWrData,
  input logic              hvOverride,
  input logic              arrayReq,
  input logic [1:0]        arrayOp,
  input logic [ADDR_W-1:0] arrayAddr,
  input logic [DATA_W-1:0] arrayWrData,
  input logic              arrayKeepBoot,
  input logic              busy,
  input logic              bootLocked
);

  logic reqBoot;
  always_comb begin
    if (BOOT_TOP) reqBoot = (arrayAddr >> BOOT_LOG2) == ({ADDR_W{1'b1}} >> BOOT_LOG2);
    else          reqBoot = (arrayAddr >> BOOT_LOG2) == '0;
  end

  // R2: a request lasts a single cycle
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arrayReq |=> !arrayReq);

  // R3: a program never sets a bit the new byte holds at 0
  assert_pgm_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arrayReq && arrayOp == OP_PROGRAM) |-> ((arrayWrData & ~$past(busWrData)) == '0));

  // R5: the lock is sticky
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bootLocked |=> bootLocked);

  // R6: no program into a locked boot region without the override
  assert_boot_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arrayReq && arrayOp == OP_PROGRAM && reqBoot) |-> ($past(hvOverride) || !$past(bootLocked)));

  // R11: no new request while an operation is outstanding
  assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !arrayReq);

  // R11: busy accompanies every request
  assert_busy_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arrayReq |-> busy);

  // R7: keep-boot flag only when the lock was in force and no override
  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arrayReq && arrayOp == OP_ERASE && arrayKeepBoot) |-> ($past(bootLocked) && !$past(hvOverride)));

endmodule

bind flash_cmd_decoder flash_cmd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP), .BOOT_LOG2(BOOT_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busWrData(busWrData), .hvOverride(hvOverride),
  .arrayReq(arrayReq), .arrayOp(arrayOp), .arrayAddr(arrayAddr),
  .arrayWrData(arrayWrData), .arrayKeepBoot(arrayKeepBoot), .busy(busy),
  .bootLocked(bootLocked)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int ACK_DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic busCe_n = 1'b1, busOe_n = 1'b1, busWe_n = 1'b1, hvOverride = 1'b0;

  logic [7:0] rdA, rdB, arrRdA, arrRdB, wdA, wdB;
  logic [19:0] raA, raB, adA, adB;
  logic reqA, reqB, keepA, keepB, ackA, ackB, busyA, busyB, lockA, lockB, idA, idB;
  logic [1:0] opA, opB;

  always #4 clk = ~clk;

  assign arrRdA = raA[7:0] ^ 8'hC3;
  assign arrRdB = raB[7:0] ^ 8'hC3;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData), .busRdData(rdA),
    .busCe_n(busCe_n), .busOe_n(busOe_n), .busWe_n(busWe_n), .hvOverride(hvOverride),
    .arrayRdAddr(raA), .arrayRdData(arrRdA), .arrayReq(reqA), .arrayOp(opA),
    .arrayAddr(adA), .arrayWrData(wdA), .arrayKeepBoot(keepA), .arrayAck(ackA),
    .busy(busyA), .bootLocked(lockA), .idMode(idA));

  flash_cmd_decoder #(.BOOT_TOP(1'b1), .INIT_LOCKED(1'b1)) dutTop (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData), .busRdData(rdB),
    .busCe_n(busCe_n), .busOe_n(busOe_n), .busWe_n(busWe_n), .hvOverride(hvOverride),
    .arrayRdAddr(raB), .arrayRdData(arrRdB), .arrayReq(reqB), .arrayOp(opB),
    .arrayAddr(adB), .arrayWrData(wdB), .arrayKeepBoot(keepB), .arrayAck(ackB),
    .busy(busyB), .bootLocked(lockB), .idMode(idB));

  // array acknowledge model
  int ackCntA = 0, ackCntB = 0;
  always @(posedge clk) begin
    ackA <= 1'b0;
    ackB <= 1'b0;
    if (reqA) ackCntA <= ACK_DLY;
    else if (ackCntA > 0) begin ackCntA <= ackCntA - 1; if (ackCntA == 1) ackA <= 1'b1; end
    if (reqB) ackCntB <= ACK_DLY;
    else if (ackCntB > 0) begin ackCntB <= ackCntB - 1; if (ackCntB == 1) ackB <= 1'b1; end
  end

  // request monitor
  int nReqA = 0, nReqB = 0, pulseLenA = 0, maxPulseA = 0;
  logic [1:0] lOpA, lOpB;
  logic [19:0] lAdA, lAdB;
  logic [7:0] lWdA;
  logic lKeepA, lKeepB;
  always @(negedge clk) begin
    if (reqA) begin
      nReqA <= nReqA + 1; lOpA <= opA; lAdA <= adA; lWdA <= wdA; lKeepA <= keepA;
      pulseLenA <= pulseLenA + 1;
      if (pulseLenA + 1 > maxPulseA) maxPulseA <= pulseLenA + 1;
    end else pulseLenA <= 0;
    if (reqB) begin
      nReqB <= nReqB + 1; lOpB <= opB; lAdB <= adB; lKeepB <= keepB;
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] oldByte(input logic [19:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction

  task automatic busWrite(input logic [19:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    busAddr = a; busWrData = d; busCe_n = 1'b0; busWe_n = 1'b0; busOe_n = 1'b1;
    repeat (hold) @(negedge clk);
    busCe_n = 1'b1; busWe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [19:0] a, output logic [7:0] va, output logic [7:0] vb);
    @(negedge clk);
    busAddr = a; busCe_n = 1'b0; busOe_n = 1'b0; busWe_n = 1'b1;
    #1 va = rdA; vb = rdB;
    @(negedge clk);
    busCe_n = 1'b1; busOe_n = 1'b1;
  endtask

  task automatic unlock();
    busWrite(20'h05555, 8'hAA);
    busWrite(20'h02AAA, 8'h55);
  endtask

  task automatic seqProgram(input logic [19:0] a, input logic [7:0] d);
    unlock(); busWrite(20'h05555, 8'hA0); busWrite(a, d);
  endtask

  task automatic seqSix(input logic [7:0] code);
    unlock(); busWrite(20'h05555, 8'h80); unlock(); busWrite(20'h05555, code);
  endtask

  task automatic waitIdle();
    while (busyA || busyB) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R12 arrayReq after reset", reqA, 0);
    chk("R12 busy after reset", busyA, 0);
    chk("R12 idMode after reset", idA, 0);
    chk("R5 lock reset value INIT_LOCKED=0", lockA, 0);
    chk("R5 lock reset value INIT_LOCKED=1", lockB, 1);
  endtask

  task automatic t_program();
    int n0 = nReqA;
    seqProgram(20'h12345, 8'h5A);
    chk("R2 one request", nReqA - n0, 1);
    chk("R2 opcode", lOpA, 1);
    chk("R2 target", lAdA, 20'h12345);
    chk("R2 pulse width", maxPulseA, 1);
    chk("R3 old AND new", lWdA, oldByte(20'h12345) & 8'h5A);
    waitIdle();
  endtask

  task automatic t_writeQual();
    int n0 = nReqA;
    unlock(); busWrite(20'h05555, 8'hA0);
    @(negedge clk);
    busAddr = 20'h20000; busWrData = 8'h0F; busCe_n = 1'b0; busWe_n = 1'b0; busOe_n = 1'b0;
    repeat (2) @(negedge clk);
    busCe_n = 1'b1; busWe_n = 1'b1; busOe_n = 1'b1;
    @(negedge clk);
    chk("R1 write with oe low ignored", nReqA - n0, 0);
    busWrite(20'h20001, 8'h3C, 4);
    chk("R1 held write counted once", nReqA - n0, 1);
    chk("R1 target after ignored cycle", lAdA, 20'h20001);
    waitIdle();
  endtask

  task automatic t_busy();
    int n0 = nReqA;
    seqProgram(20'h30000, 8'hFF);
    chk("R11 busy after request", busyA, 1);
    seqProgram(20'h30001, 8'hFF);
    chk("R11 writes ignored while busy", nReqA - n0, 1);
    waitIdle();
    chk("R11 busy released after ack", busyA, 0);
    busWrite(20'h30002, 8'h11);
    chk("R11 no armed state survives busy window", nReqA - n0, 1);
  endtask

  task automatic t_mismatch();
    int n0 = nReqA;
    busWrite(20'h05555, 8'hAA);
    unlock(); busWrite(20'h05555, 8'hA0); busWrite(20'h40000, 8'h77);
    chk("R10 repeated first key restarts", nReqA - n0, 1);
    waitIdle();
    n0 = nReqA;
    unlock(); busWrite(20'h05555, 8'h33); busWrite(20'h40001, 8'h77);
    chk("R10 bad code returns to idle", nReqA - n0, 0);
  endtask

  task automatic t_eraseOpen();
    int n0 = nReqA;
    seqSix(8'h10);
    chk("R4 erase request", nReqA - n0, 1);
    chk("R4 erase opcode", lOpA, 2);
    chk("R4 keep boot unlocked", lKeepA, 0);
    chk("R4 keep boot locked (top variant)", lKeepB, 1);
    waitIdle();
  endtask

  task automatic t_idMode();
    logic [7:0] va, vb;
    unlock(); busWrite(20'h05555, 8'h90);
    chk("R8 id mode entered", idA, 1);
    busRead(20'h00002, va, vb);
    chk("R8 status read unlocked", va, 8'h00);
    chk("R8 status read locked variant", vb, 8'h01);
    busRead(20'h00005, va, vb);
    chk("R8 other address reads zero", va, 8'h00);
    busWrite(20'h12345, 8'hF0);
    chk("R9 single F0 exits", idA, 0);
    busRead(20'h00002, va, vb);
    chk("R8 normal read passes array", va, oldByte(20'h00002));
    unlock(); busWrite(20'h05555, 8'h90);
    unlock(); busWrite(20'h05555, 8'hF0);
    chk("R9 three-write exit", idA, 0);
  endtask

  task automatic t_lock();
    logic [7:0] va, vb;
    int n0 = nReqA;
    seqSix(8'h40);
    chk("R5 lock set", lockA, 1);
    chk("R5 lock issues no array request", nReqA - n0, 0);
    unlock(); busWrite(20'h05555, 8'h90);
    busRead(20'h00002, va, vb);
    chk("R8 status shows lock", va, 8'h01);
    busWrite(20'h00000, 8'hF0);
    seqSix(8'h10);
    chk("R4 erase while locked keeps boot", lKeepA, 1);
    waitIdle();
    chk("R5 lock survives erase", lockA, 1);
  endtask

  task automatic t_boot();
    int a0 = nReqA, b0 = nReqB;
    seqProgram(20'h03FFF, 8'h00);
    chk("R6 bottom boot program refused", nReqA - a0, 0);
    chk("R6 low address outside top region", nReqB - b0, 1);
    waitIdle();
    a0 = nReqA; b0 = nReqB;
    seqProgram(20'h04000, 8'h00);
    chk("R6 just above bottom region allowed", nReqA - a0, 1);
    waitIdle();
    a0 = nReqA; b0 = nReqB;
    seqProgram(20'hFC000, 8'h00);
    chk("R6 top boot program refused", nReqB - b0, 0);
    chk("R6 top address outside bottom region", nReqA - a0, 1);
    waitIdle();
  endtask

  task automatic t_override();
    int a0 = nReqA, b0 = nReqB;
    hvOverride = 1'b1;
    seqProgram(20'h00010, 8'h0F);
    chk("R7 override permits boot program", nReqA - a0, 1);
    chk("R7 override program data", lWdA, oldByte(20'h00010) & 8'h0F);
    waitIdle();
    seqSix(8'h10);
    chk("R7 override erase clears keep", lKeepA, 0);
    chk("R7 override erase clears keep top", lKeepB, 0);
    waitIdle();
    hvOverride = 1'b0;
    b0 = nReqB;
    seqProgram(20'hFFFFF, 8'h00);
    chk("R7 protection back after override drops", nReqB - b0, 0);
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_writeQual();
    t_busy();
    t_mismatch();
    t_eraseOpen();
    t_idMode();
    t_lock();
    t_boot();
    t_override();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule